// File: doc/BRIEF.md
# Configurable Logic Cell

This block is a small programmable glue-logic cell. Eight single-bit input lines feed four data selectors. Each selector routes one line onto a data signal. Four data gates each form an OR of any chosen data signals, taken in true or inverted form, and then apply a per-gate inversion. The four gate signals g1 to g4 drive a logic core. A 3-bit mode field turns the core into one of eight elements: three combinational functions and five storage elements. The core result goes through an output inversion and is offered as the cell output. A separate output-enable strobe says whether that result should drive a pin. Rising and falling edges of the final output can raise a sticky interrupt flag.

The single storage bit in the core is held as a two-state machine with states CORE_LO and CORE_HI. Every transition is evaluated on the system clock and falls into one of four kinds:

- CLEAR: reset gate, or cell disabled.
- SET: set gate.
- CAPTURE: a clocked mode sees a sampled rising edge of g1, or the transparent latch is open.
- HOLD: anything else.

Reset and set also override the output combinationally, so their effect is seen without waiting for a clock. Each clock edge samples g1, and a rising edge of that sample stands in for the clock of the element.

Top module: `glue_cell`

## Requirements
- R1: Data selector k (k = 0..3) uses cfg_sel[3k+2:3k] as a binary line number: code n routes in_lines[n] onto data signal k, for n from 0 to 7.
- R2: Gate j (j = 0..3, gate j is g(j+1)) computes an OR and then an XOR with cfg_gate_pol[j]. The OR takes data k where cfg_gate_en[8j+2k] is set and NOT data k where cfg_gate_en[8j+2k+1] is set. A gate with no enabled terms outputs cfg_gate_pol[j].
- R3: The combinational modes work as follows: mode 000 gives (g1&g2)|(g3&g4), mode 001 gives (g1|g2)^(g3|g4), and mode 010 gives g1&g2&g3&g4. In these modes the core output follows the inputs with no clock.
- R4: Mode 011 is a set/reset latch with set = g1|g2 and reset = g3|g4. Reset wins over set, and both act at once on the output. With both low, the output holds its value.
- R5: Mode 100 is a D flip-flop with D = g2, reset g3 and set g4, where reset wins and both act at once. When a clock edge first samples g1 high after a sample of g1 low, D is captured, and the output shows it after that edge.
- R6: Mode 101 is a D flip-flop clocked like R5, with D = g2 XOR g4 and reset g3. It has no set, so g4 alone does not raise the output.
- R7: Mode 110 is a J-K flip-flop clocked like R5, with J = g2, K = g4 and reset g3. J=K=1 toggles the output on each g1 edge.
- R8: Mode 111 is a transparent latch with enable g1, D = g2, reset g3 and set g4, where reset wins. While g1 is high the output follows D at once. While g1 is low it holds the last value.
- R9: With cell_en low, the core output is 0, so cell_out equals cfg_out_pol, and the storage bit is cleared. After re-enabling, a storage mode with no set, reset or capture active outputs 0 before polarity.
- R10: cell_out is the core output XOR cfg_out_pol.
- R11: A rising edge of cell_out with cfg_irq_rise set, or a falling edge with cfg_irq_fall set, sets irq_flag at the clock edge that first samples the new value. An edge whose enable is low does not set the flag.
- R12: irq_flag stays set until a clock edge samples irq_clr high. If an enabled edge is detected in that same cycle, the flag stays set. Reset clears the flag.
- R13: pin_oe equals cfg_out_en, and cell_out does not depend on cfg_out_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cell_en | input | 1 | Cell enable |
| in_lines | input | 8 | Candidate input lines |
| cfg_mode | input | 3 | Core function select |
| cfg_sel | input | 12 | Four 3-bit line selects |
| cfg_gate_en | input | 32 | True/inverted term enables, 8 per gate |
| cfg_gate_pol | input | 4 | Per-gate output inversion |
| cfg_out_pol | input | 1 | Output inversion |
| cfg_irq_rise | input | 1 | Rising-edge flag enable |
| cfg_irq_fall | input | 1 | Falling-edge flag enable |
| cfg_out_en | input | 1 | Pin drive enable |
| irq_clr | input | 1 | Flag clear strobe |
| cell_out | output | 1 | Cell result, always readable |
| pin_oe | output | 1 | Pin drive strobe |
| irq_flag | output | 1 | Sticky edge flag |

## Verification
A wrong storage state shows up on cell_out in the same cycle whenever no set, reset or open latch is masking it. In the clocked modes it appears just after the first clock edge that samples a new g1 edge. A stale edge sample shows as a capture that is missing or doubled on the output one cycle after g1 rises. A wrong edge register or flag state shows on irq_flag one edge after cell_out moves. Once set, a wrong flag persists until the next clear.

// File: rtl/glue_pkg.sv
package glue_pkg;
    localparam int NGATE = 4;

    typedef enum logic [2:0] {
        MODE_AND_OR  = 3'b000,
        MODE_OR_XOR  = 3'b001,
        MODE_AND4    = 3'b010,
        MODE_SR      = 3'b011,
        MODE_DFF_SR  = 3'b100,
        MODE_DFF_R2  = 3'b101,
        MODE_JK      = 3'b110,
        MODE_LATCH   = 3'b111
    } mode_t;

    typedef enum logic {
        CORE_LO = 1'b0,
        CORE_HI = 1'b1
    } core_st_t;
endpackage

// File: rtl/glue_select.sv
module glue_select #(
    parameter int NLINE = 8,
    parameter int NDATA = 4,
    localparam int SELW = $clog2(NLINE)
) (
    input  logic [NLINE-1:0]      lines,
    input  logic [NDATA*SELW-1:0] sel,
    output logic [NDATA-1:0]      data
);
    for (genvar k = 0; k < NDATA; k++) begin : g_sel
        assign data[k] = lines[sel[k*SELW +: SELW]];
    end
endmodule

// File: rtl/glue_gates.sv
module glue_gates #(
    parameter int NDATA = 4,
    parameter int NGATE = 4,
    localparam int TPG = 2 * NDATA
) (
    input  logic [NDATA-1:0]     data,
    input  logic [NGATE*TPG-1:0] en,
    input  logic [NGATE-1:0]     pol,
    output logic [NGATE-1:0]     g
);
    for (genvar j = 0; j < NGATE; j++) begin : g_gate
        logic acc;
        always_comb begin
            acc = 1'b0;
            for (int k = 0; k < NDATA; k++) begin
                acc = acc | (en[j*TPG + 2*k] & data[k])
                          | (en[j*TPG + 2*k + 1] & ~data[k]);
            end
        end
        assign g[j] = acc ^ pol[j];
    end
endmodule

// File: rtl/glue_core.sv
module glue_core
    import glue_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cell_en,
    input  mode_t            mode,
    input  logic [NGATE-1:0] g,
    output logic             core_out
);
    core_st_t state, state_nx;
    logic g1_prev;
    logic d, s, r, le, clocked, jk, comb_mode, comb_val, edge_g1, seq_q;

    // role of each gate in the selected mode
    always_comb begin
        d         = g[1];
        s         = 1'b0;
        r         = g[2];
        le        = 1'b0;
        clocked   = 1'b0;
        jk        = 1'b0;
        comb_mode = 1'b0;
        comb_val  = 1'b0;
        unique case (mode)
            MODE_AND_OR: begin
                comb_mode = 1'b1;
                r         = 1'b0;
                comb_val  = (g[0] & g[1]) | (g[2] & g[3]);
            end
            MODE_OR_XOR: begin
                comb_mode = 1'b1;
                r         = 1'b0;
                comb_val  = (g[0] | g[1]) ^ (g[2] | g[3]);
            end
            MODE_AND4: begin
                comb_mode = 1'b1;
                r         = 1'b0;
                comb_val  = &g;
            end
            MODE_SR: begin
                s = g[0] | g[1];
                r = g[2] | g[3];
            end
            MODE_DFF_SR: begin
                s       = g[3];
                clocked = 1'b1;
            end
            MODE_DFF_R2: begin
                d       = g[1] ^ g[3];
                clocked = 1'b1;
            end
            MODE_JK: begin
                clocked = 1'b1;
                jk      = 1'b1;
            end
            MODE_LATCH: begin
                s  = g[3];
                le = g[0];
            end
        endcase
    end

    assign edge_g1 = g[0] & ~g1_prev;

    // next-state process: CLEAR, SET, CAPTURE, HOLD
    always_comb begin
        state_nx = state;
        unique case (state)
            CORE_LO: begin
                if (!cell_en || r)            state_nx = CORE_LO;
                else if (s)                   state_nx = CORE_HI;
                else if (clocked && edge_g1)  state_nx = (jk ? g[1] : d) ? CORE_HI : CORE_LO;
                else if (le)                  state_nx = d ? CORE_HI : CORE_LO;
                else                          state_nx = CORE_LO;
            end
            CORE_HI: begin
                if (!cell_en || r)            state_nx = CORE_LO;
                else if (s)                   state_nx = CORE_HI;
                else if (clocked && edge_g1)  state_nx = (jk ? ~g[3] : d) ? CORE_HI : CORE_LO;
                else if (le)                  state_nx = d ? CORE_HI : CORE_LO;
                else                          state_nx = CORE_HI;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= CORE_LO;
            g1_prev <= 1'b0;
        end else begin
            state   <= state_nx;
            g1_prev <= g[0];
        end
    end

    // output process
    always_comb begin
        if (r)       seq_q = 1'b0;
        else if (s)  seq_q = 1'b1;
        else if (le) seq_q = d;
        else         seq_q = (state == CORE_HI);
        if (!cell_en)       core_out = 1'b0;
        else if (comb_mode) core_out = comb_val;
        else                core_out = seq_q;
    end
endmodule

// File: rtl/glue_irq.sv
module glue_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic sig,
    input  logic rise_en,
    input  logic fall_en,
    input  logic clr,
    output logic flag
);
    logic sig_prev;
    logic hit;

    always_ff @(posedge clk) begin
        sig_prev <= sig;
    end

    assign hit = (rise_en & sig & ~sig_prev) | (fall_en & ~sig & sig_prev);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag <= 1'b0;
        else        flag <= hit | (flag & ~clr);
    end
endmodule

// File: rtl/glue_cell.sv
module glue_cell
    import glue_pkg::*;
#(
    parameter int NLINE = 8,
    parameter int NDATA = 4,
    localparam int SELW = $clog2(NLINE),
    localparam int GENW = NGATE * NDATA * 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cell_en,
    input  logic [NLINE-1:0]      in_lines,
    input  logic [2:0]            cfg_mode,
    input  logic [NDATA*SELW-1:0] cfg_sel,
    input  logic [GENW-1:0]       cfg_gate_en,
    input  logic [NGATE-1:0]      cfg_gate_pol,
    input  logic                  cfg_out_pol,
    input  logic                  cfg_irq_rise,
    input  logic                  cfg_irq_fall,
    input  logic                  cfg_out_en,
    input  logic                  irq_clr,
    output logic                  cell_out,
    output logic                  pin_oe,
    output logic                  irq_flag
);
    logic [NDATA-1:0] data;
    logic [NGATE-1:0] gsig;
    logic             core_out;

    glue_select #(.NLINE(NLINE), .NDATA(NDATA)) i_select (
        .lines (in_lines),
        .sel   (cfg_sel),
        .data  (data)
    );

    glue_gates #(.NDATA(NDATA), .NGATE(NGATE)) i_gates (
        .data  (data),
        .en    (cfg_gate_en),
        .pol   (cfg_gate_pol),
        .g     (gsig)
    );

    glue_core i_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .cell_en  (cell_en),
        .mode     (mode_t'(cfg_mode)),
        .g        (gsig),
        .core_out (core_out)
    );

    assign cell_out = core_out ^ cfg_out_pol;
    assign pin_oe   = cfg_out_en;

    glue_irq i_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .sig     (cell_out),
        .rise_en (cfg_irq_rise),
        .fall_en (cfg_irq_fall),
        .clr     (irq_clr),
        .flag    (irq_flag)
    );
endmodule

// File: rtl/glue_cell_chk.sv
module glue_cell_chk (
    input logic clk,
    input logic rst_n,
    input logic cell_en,
    input logic cfg_out_pol,
    input logic cfg_irq_rise,
    input logic cfg_irq_fall,
    input logic irq_clr,
    input logic cell_out,
    input logic irq_flag
);
    // R11
    rise_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(cell_out) && cfg_irq_rise) |=> irq_flag);

    // R11
    fall_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cell_out) && cfg_irq_fall) |=> irq_flag);

    // R12
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_flag && !irq_clr) |=> irq_flag);

    // R12
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_clr && !cfg_irq_rise && !cfg_irq_fall) |=> !irq_flag);

    // R9
    disabled_output_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cell_en |-> (cell_out == cfg_out_pol));
endmodule

bind glue_cell glue_cell_chk i_glue_cell_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cell_en      (cell_en),
    .cfg_out_pol  (cfg_out_pol),
    .cfg_irq_rise (cfg_irq_rise),
    .cfg_irq_fall (cfg_irq_fall),
    .irq_clr      (irq_clr),
    .cell_out     (cell_out),
    .irq_flag     (irq_flag)
);

// File: tb/test_glue_cell.sv
module test_glue_cell;
    localparam int PERIOD = 10;
    localparam logic [11:0] ID  = 12'h688;
    localparam logic [31:0] TRU = 32'h40100401;
    localparam int NVEC = 22;
    // fields: mode[60:58] sel[57:46] gate_en[45:14] gate_pol[13:10] out_pol[9] lines[8:1] exp[0]
    localparam logic [60:0] VEC [NVEC] = '{
        {3'b000, ID, TRU, 4'h0, 1'b0, 8'h03, 1'b1},        // R3 and-or
        {3'b000, ID, TRU, 4'h0, 1'b0, 8'h05, 1'b0},        // R3
        {3'b000, ID, TRU, 4'h0, 1'b0, 8'h0C, 1'b1},        // R3
        {3'b000, ID, TRU, 4'h0, 1'b1, 8'h05, 1'b1},        // R10
        {3'b001, ID, TRU, 4'h0, 1'b0, 8'h01, 1'b1},        // R3 or-xor
        {3'b001, ID, TRU, 4'h0, 1'b0, 8'h05, 1'b0},        // R3
        {3'b001, ID, TRU, 4'h0, 1'b0, 8'h00, 1'b0},        // R3
        {3'b001, ID, TRU, 4'h0, 1'b0, 8'h08, 1'b1},        // R3
        {3'b010, ID, TRU, 4'h0, 1'b0, 8'h0F, 1'b1},        // R3 and4
        {3'b010, ID, TRU, 4'h0, 1'b0, 8'h07, 1'b0},        // R3
        {3'b010, ID, TRU, 4'hF, 1'b0, 8'h00, 1'b1},        // R2 gate pol
        {3'b010, ID, TRU, 4'h1, 1'b0, 8'h0F, 1'b0},        // R2
        {3'b010, 12'hFFF, TRU, 4'h0, 1'b0, 8'h80, 1'b1},   // R1 code 7
        {3'b010, 12'hFFF, TRU, 4'h0, 1'b0, 8'h7F, 1'b0},   // R1
        {3'b010, ID, 32'h0, 4'hF, 1'b0, 8'h55, 1'b1},      // R2 no terms
        {3'b010, ID, 32'h0, 4'h7, 1'b0, 8'h55, 1'b0},      // R2
        {3'b010, ID, 32'h5, 4'hE, 1'b0, 8'h02, 1'b1},      // R2 two terms
        {3'b010, ID, 32'h5, 4'hE, 1'b0, 8'h00, 1'b0},      // R2
        {3'b010, ID, 32'h80200802, 4'h0, 1'b0, 8'h00, 1'b1}, // R2 inverted
        {3'b010, ID, 32'h80200802, 4'h0, 1'b0, 8'h01, 1'b0}, // R2
        {3'b010, 12'hB6D, TRU, 4'h0, 1'b0, 8'h20, 1'b1},   // R1 code 5
        {3'b010, 12'hB6D, TRU, 4'h0, 1'b0, 8'hDF, 1'b0}    // R1
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cell_en = 1'b0;
    logic [7:0] in_lines = 8'h00;
    logic [2:0] cfg_mode = 3'b000;
    logic [11:0] cfg_sel = ID;
    logic [31:0] cfg_gate_en = TRU;
    logic [3:0] cfg_gate_pol = 4'h0;
    logic cfg_out_pol = 1'b0;
    logic cfg_irq_rise = 1'b0;
    logic cfg_irq_fall = 1'b0;
    logic cfg_out_en = 1'b0;
    logic irq_clr = 1'b0;
    logic cell_out, pin_oe, irq_flag;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    glue_cell i_glue_cell (
        .clk(clk), .rst_n(rst_n), .cell_en(cell_en), .in_lines(in_lines),
        .cfg_mode(cfg_mode), .cfg_sel(cfg_sel), .cfg_gate_en(cfg_gate_en),
        .cfg_gate_pol(cfg_gate_pol), .cfg_out_pol(cfg_out_pol),
        .cfg_irq_rise(cfg_irq_rise), .cfg_irq_fall(cfg_irq_fall),
        .cfg_out_en(cfg_out_en), .irq_clr(irq_clr),
        .cell_out(cell_out), .pin_oe(pin_oe), .irq_flag(irq_flag)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic settle();
        #(PERIOD/4);
    endtask

    task automatic lines(input logic [3:0] v);
        in_lines = {4'h0, v};
        settle();
    endtask

    initial begin
        #(PERIOD * 20000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        settle();
        chk("R12 reset flag", irq_flag, 1'b0);
        chk("R9 reset disabled out", cell_out, 1'b0);
        cfg_out_pol = 1'b1;
        settle();
        chk("R9 disabled out pol", cell_out, 1'b1);
        cfg_out_pol = 1'b0;
        cell_en = 1'b1;

        // combinational table
        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            cfg_mode     = VEC[i][60:58];
            cfg_sel      = VEC[i][57:46];
            cfg_gate_en  = VEC[i][45:14];
            cfg_gate_pol = VEC[i][13:10];
            cfg_out_pol  = VEC[i][9];
            in_lines     = VEC[i][8:1];
            settle();
            chk($sformatf("R1/R2/R3 vector %0d", i), cell_out, VEC[i][0]);
        end
        @(negedge clk);
        cfg_sel = ID; cfg_gate_en = TRU; cfg_gate_pol = 4'h0; cfg_out_pol = 1'b0;

        // R13
        cfg_mode = 3'b000; lines(4'b0011);
        cfg_out_en = 1'b1; settle();
        chk("R13 oe high", pin_oe, 1'b1);
        chk("R13 out unaffected", cell_out, 1'b1);
        cfg_out_en = 1'b0; settle();
        chk("R13 oe low", pin_oe, 1'b0);
        chk("R13 out unaffected low oe", cell_out, 1'b1);

        // R4 set/reset latch
        cfg_mode = 3'b011;
        lines(4'b0100); step();
        lines(4'b0010);
        chk("R4 set immediate", cell_out, 1'b1);
        step(); lines(4'b0000); step();
        chk("R4 hold", cell_out, 1'b1);
        lines(4'b1000);
        chk("R4 reset immediate", cell_out, 1'b0);
        lines(4'b0101);
        chk("R4 reset wins", cell_out, 1'b0);
        step(); lines(4'b0000); step();
        chk("R4 hold low", cell_out, 1'b0);

        // R5 D flip-flop with set and reset
        cfg_mode = 3'b100;
        lines(4'b0010); step();
        chk("R5 no edge", cell_out, 1'b0);
        lines(4'b0011); step();
        chk("R5 capture 1", cell_out, 1'b1);
        lines(4'b0001); step();
        chk("R5 no recapture while high", cell_out, 1'b1);
        lines(4'b0000); step(); lines(4'b0001); step();
        chk("R5 capture 0", cell_out, 1'b0);
        lines(4'b1000);
        chk("R5 set immediate", cell_out, 1'b1);
        step(); lines(4'b0000); step();
        chk("R5 set stored", cell_out, 1'b1);
        lines(4'b1100);
        chk("R5 reset wins", cell_out, 1'b0);
        step(); lines(4'b0000); step();

        // R6 two-input D flip-flop
        cfg_mode = 3'b101;
        lines(4'b1000); step();
        chk("R6 no set from g4", cell_out, 1'b0);
        lines(4'b1001); step();
        chk("R6 capture xor", cell_out, 1'b1);
        lines(4'b1000); step(); lines(4'b1011); step();
        chk("R6 capture xor low", cell_out, 1'b0);

        // R7 J-K flip-flop
        cfg_mode = 3'b110;
        lines(4'b0100); step();
        lines(4'b0010); step(); lines(4'b0011); step();
        chk("R7 J sets", cell_out, 1'b1);
        lines(4'b1010); step(); lines(4'b1011); step();
        chk("R7 toggle to 0", cell_out, 1'b0);
        lines(4'b1010); step(); lines(4'b1011); step();
        chk("R7 toggle to 1", cell_out, 1'b1);
        lines(4'b1000); step(); lines(4'b1001); step();
        chk("R7 K clears", cell_out, 1'b0);

        // R8 transparent latch
        cfg_mode = 3'b111;
        lines(4'b0011);
        chk("R8 transparent 1", cell_out, 1'b1);
        lines(4'b0001);
        chk("R8 transparent 0", cell_out, 1'b0);
        lines(4'b0011); step();
        lines(4'b0000); step();
        chk("R8 hold closed", cell_out, 1'b1);
        lines(4'b0100);
        chk("R8 reset", cell_out, 1'b0);
        step(); lines(4'b1000); step(); lines(4'b0000); step();
        chk("R8 set stored", cell_out, 1'b1);

        // R9 disable clears storage
        cell_en = 1'b0; settle();
        chk("R9 disabled out", cell_out, 1'b0);
        step();
        cell_en = 1'b1; settle();
        chk("R9 storage cleared", cell_out, 1'b0);

        // R11 / R12 interrupt flag
        cfg_mode = 3'b000;
        lines(4'b0000); step();
        irq_clr = 1'b1; step(); irq_clr = 1'b0;
        cfg_irq_rise = 1'b1;
        lines(4'b0011); step();
        chk("R11 rise sets flag", irq_flag, 1'b1);
        step(); step();
        chk("R12 flag sticky", irq_flag, 1'b1);
        irq_clr = 1'b1; step(); irq_clr = 1'b0;
        chk("R12 clear", irq_flag, 1'b0);
        lines(4'b0000); step();
        chk("R11 fall ignored", irq_flag, 1'b0);
        cfg_irq_rise = 1'b0; cfg_irq_fall = 1'b1;
        lines(4'b0011); step();
        chk("R11 rise ignored", irq_flag, 1'b0);
        lines(4'b0000); step();
        chk("R11 fall sets flag", irq_flag, 1'b1);
        cfg_irq_fall = 1'b0;
        irq_clr = 1'b1; step();
        cfg_irq_rise = 1'b1;
        lines(4'b0011); step(); irq_clr = 1'b0;
        chk("R12 set wins over clear", irq_flag, 1'b1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule